// File: doc/BRIEF.md
# Black Level Offset Controller

This block holds the black level of a digitized CCD line at a programmed target code. It watches 10-bit converter samples at the pixel rate. While a clamp strobe marks the dummy black pixels at the start of a line, and the automatic loop is enabled, it sums groups of eight black samples. It compares their average with a target code, scales the difference by a selectable power of two, and adds the result to a saturating signed offset. That offset is registered and sent as an 8-bit two's complement word to the offset DAC. It can also be steered onto the data output bus in place of the video samples.

When the automatic loop is off, the offset comes from one of four preset registers, chosen at pixel rate by a line-select input. Software can rewrite these registers between lines. When the auxiliary video source is selected, preset 0 is used whatever the mode. All settings are written through a plain parallel write port.

Top module: `blc_loop`

## Requirements
- R1: A synchronous reset (`rst` high) clears every register, the integrator and both outputs to zero, which selects manual mode with scale code 0 and no routing.
- R2: A write with `wr_en` high stores `wr_data` on the next clock edge. Address 0 is control: bit 0 enables the automatic loop, bits 2:1 are the scale code and bit 3 routes the offset to the data bus. Address 1 is the 10-bit target code. Addresses 2 to 5 are presets 0 to 3, each taking the low 8 bits. The outputs reflect a write one clock after it is stored.
- R3: A sample is taken into the average only on a clock edge where `pix_en`, `clamp` and the automatic-enable bit are all high. Samples are ignored at all other times, including while the loop is disabled.
- R4: After eight samples have been taken, the integrator updates on the following clock edge using error = target − floor(sum / 8). The new offset reaches `dac_ofs` one edge after that.
- R5: The scale code shifts the error right arithmetically: code 0 by 0 bits, code 1 by 1, code 2 by 2 and code 3 by 4. Negative errors therefore round towards minus infinity (−3 with code 2 gives −1).
- R6: The integrator adds the scaled error and saturates at −128 and +127 without wrapping. It holds its value on every edge where no update takes place.
- R7: If `clamp` goes low before eight samples have been taken, the partial group is discarded and the offset does not change.
- R8: In manual mode, `dac_ofs` shows preset[`line_sel`] one clock after `line_sel` or the preset changes.
- R9: While `aux_sel` is high, `dac_ofs` shows preset 0 regardless of mode and of `line_sel`.
- R10: With the routing bit set, `dac_ofs` is zero and `dout` carries the selected offset sign-extended to 10 bits. With the routing bit clear, `dout` is `sample` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate clock enable |
| clamp | input | 1 | Marks dummy black pixels |
| aux_sel | input | 1 | Auxiliary video source selected |
| sample | input | 10 | Converted pixel sample |
| line_sel | input | 2 | Preset selector for manual mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 10 | Register write data |
| dac_ofs | output | 8 | Two's complement offset word for the DAC |
| dout | output | 10 | Data output bus: samples or routed offset |

## Verification
The hardest states to reach are the integrator limits and the partial group that must be thrown away. To drive the integrator to +127, the stimulus programs the maximum target and feeds all-zero black groups. Feeding full-scale groups against a zero target then drives it to −128. A discarded group is shown by a strobe of five samples followed by one of three. If the five were wrongly kept, those three would complete a group and visibly move the offset. Pixel-enable gaps filled with large samples show that only qualified samples enter the average.

// File: rtl/blc_pkg.sv
package blc_pkg;

   // control register layout, bit 0 is the automatic enable
   typedef struct packed {
      logic       route;
      logic [1:0] scale;
      logic       auto_en;
   } blc_ctrl_t;

   localparam int CTRL_BITS = 4;

   function automatic int unsigned scale_shift(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 1;
         2'd2:    return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/blc_regs.sv
module blc_regs
   import blc_pkg::*;
#(
   parameter int SAMPLE_W   = 10,
   parameter int OFS_W      = 8,
   parameter int NUM_PRESET = 4,
   parameter int ADDR_W     = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [SAMPLE_W-1:0]     wr_data,
   output blc_ctrl_t               ctrl,
   output logic [SAMPLE_W-1:0]     target,
   output logic signed [OFS_W-1:0] preset [NUM_PRESET]
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(1);
   localparam int                A_PRE0 = 2;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl   <= '0;
         target <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) ctrl   <= blc_ctrl_t'(wr_data[CTRL_BITS-1:0]);
         if (wr_addr == A_TGT)  target <= wr_data;
      end
   end

   for (genvar k = 0; k < NUM_PRESET; k++) begin : g_preset
      always_ff @(posedge clk) begin
         if (rst)
            preset[k] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(A_PRE0 + k))
            preset[k] <= wr_data[OFS_W-1:0];
      end
   end

endmodule

// File: rtl/blc_avg.sv
module blc_avg #(
   parameter int SAMPLE_W = 10,
   parameter int AVG_LOG2 = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                enable,
   input  logic                pix_en,
   input  logic                clamp,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                avg_vld,
   output logic [SAMPLE_W-1:0] avg
);

   localparam int ACC_W = SAMPLE_W + AVG_LOG2;
   localparam int CNT_W = AVG_LOG2 + 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << AVG_LOG2);

   logic [ACC_W-1:0] acc;
   logic [CNT_W-1:0] cnt;
   logic             take;

   assign take    = enable && clamp && pix_en;
   assign avg_vld = (cnt == FULL);
   assign avg     = acc[ACC_W-1:AVG_LOG2];

   always_ff @(posedge clk) begin
      if (rst || !enable || !clamp) begin
         cnt <= '0;
         acc <= '0;
      end else if (take) begin
         if (cnt == FULL) begin
            cnt <= CNT_W'(1);
            acc <= ACC_W'(sample);
         end else begin
            cnt <= cnt + 1'b1;
            acc <= acc + ACC_W'(sample);
         end
      end else if (cnt == FULL) begin
         cnt <= '0;
         acc <= '0;
      end
   end

   // strobe low throws away any partial group
   assert_discard_R7: assert property (@(posedge clk) disable iff (rst)
      !clamp |=> (cnt == '0));

   // no qualified sample, no progress within a group
   assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
      (enable && clamp && !pix_en && cnt != FULL) |=> $stable(cnt));

endmodule

// File: rtl/blc_integ.sv
module blc_integ
   import blc_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int OFS_W    = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    upd,
   input  logic [SAMPLE_W-1:0]     avg,
   input  logic [SAMPLE_W-1:0]     target,
   input  logic [1:0]              scale,
   output logic signed [OFS_W-1:0] integ
);

   localparam int ERR_W = SAMPLE_W + 1;
   localparam int SUM_W = ERR_W + 1;
   localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OFS_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

   logic signed [ERR_W-1:0] err, scaled;
   logic signed [SUM_W-1:0] sum;
   logic signed [OFS_W-1:0] nxt;

   always_comb begin
      err    = $signed({1'b0, target}) - $signed({1'b0, avg});
      scaled = err >>> scale_shift(scale);
      sum    = SUM_W'(integ) + SUM_W'(scaled);
      if (sum > HI)      nxt = HI[OFS_W-1:0];
      else if (sum < LO) nxt = LO[OFS_W-1:0];
      else               nxt = sum[OFS_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)      integ <= '0;
      else if (upd) integ <= nxt;
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(integ));

   assert_up_R5: assert property (@(posedge clk) disable iff (rst)
      (upd && err > 0) |=> (integ >= $past(integ)));

   assert_down_R5: assert property (@(posedge clk) disable iff (rst)
      (upd && err < 0) |=> (integ <= $past(integ)));

endmodule

// File: rtl/blc_loop.sv
module blc_loop
   import blc_pkg::*;
#(
   parameter int SAMPLE_W   = 10,
   parameter int OFS_W      = 8,
   parameter int AVG_LOG2   = 3,
   parameter int NUM_PRESET = 4,
   parameter int ADDR_W     = 3,
   parameter int SEL_W      = $clog2(NUM_PRESET)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pix_en,
   input  logic                clamp,
   input  logic                aux_sel,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SEL_W-1:0]    line_sel,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [SAMPLE_W-1:0] wr_data,
   output logic [OFS_W-1:0]    dac_ofs,
   output logic [SAMPLE_W-1:0] dout
);

   localparam int EXT_W = SAMPLE_W - OFS_W;

   if (OFS_W > SAMPLE_W || OFS_W < 2)
      $error("blc_loop: OFS_W must lie in 2..SAMPLE_W");
   if (SAMPLE_W < CTRL_BITS)
      $error("blc_loop: SAMPLE_W too narrow for control word");
   if (NUM_PRESET < 2 || NUM_PRESET + 2 > (1 << ADDR_W))
      $error("blc_loop: presets do not fit the address space");
   if (AVG_LOG2 < 1)
      $error("blc_loop: AVG_LOG2 must be at least 1");

   blc_ctrl_t               ctrl;
   logic [SAMPLE_W-1:0]     target, avg;
   logic signed [OFS_W-1:0] preset [NUM_PRESET];
   logic signed [OFS_W-1:0] integ, sel;
   logic                    avg_vld;

   blc_regs #(.SAMPLE_W(SAMPLE_W), .OFS_W(OFS_W), .NUM_PRESET(NUM_PRESET),
              .ADDR_W(ADDR_W)) i_regs (
      .clk, .rst, .wr_en, .wr_addr, .wr_data,
      .ctrl, .target, .preset
   );

   blc_avg #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) i_avg (
      .clk, .rst, .enable(ctrl.auto_en), .pix_en, .clamp, .sample,
      .avg_vld, .avg
   );

   blc_integ #(.SAMPLE_W(SAMPLE_W), .OFS_W(OFS_W)) i_integ (
      .clk, .rst, .upd(avg_vld), .avg, .target, .scale(ctrl.scale),
      .integ
   );

   always_comb begin
      if (aux_sel)
         sel = preset[0];
      else if (ctrl.auto_en)
         sel = integ;
      else if (32'(line_sel) < NUM_PRESET)
         sel = preset[line_sel];
      else
         sel = preset[0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_ofs <= '0;
         dout    <= '0;
      end else begin
         dac_ofs <= ctrl.route ? '0 : sel;
         dout    <= ctrl.route ? {{EXT_W{sel[OFS_W-1]}}, sel} : sample;
      end
   end

   assert_route_R10: assert property (@(posedge clk) disable iff (rst)
      ctrl.route |=> (dac_ofs == '0));

   assert_aux_R9: assert property (@(posedge clk) disable iff (rst)
      (aux_sel && !ctrl.route) |=> (dac_ofs == $past(preset[0])));

   assert_pass_R10: assert property (@(posedge clk) disable iff (rst)
      !ctrl.route |=> (dout == $past(sample)));

endmodule

// File: tb/test_blc_loop.sv
`timescale 1ns/1ps
module test_blc_loop;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pix_en = 1'b0, clamp = 1'b0, aux_sel = 1'b0, wr_en = 1'b0;
   logic [9:0] sample = '0, wr_data = '0;
   logic [1:0] line_sel = '0;
   logic [2:0] wr_addr = '0;
   logic [7:0] dac_ofs;
   logic [9:0] dout;

   always #5 clk = ~clk;

   blc_loop i_blc_loop (
      .clk, .rst, .pix_en, .clamp, .aux_sel, .sample, .line_sel,
      .wr_en, .wr_addr, .wr_data, .dac_ofs, .dout
   );

   typedef struct {
      int         due;
      logic [7:0] dac;
      logic [9:0] dv;
      bit         chk_dout;
      string      tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    total = 0, bad = 0;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare queued expectations once outputs have settled
   always @(negedge clk) begin
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         it = q.pop_front();
         total++;
         if (it.due < cyc) begin
            bad++;
            $display("FAIL %s: stale expectation due %0d at %0d, actual dac=%0d expected dac=%0d",
                     it.tag, it.due, cyc, dac_ofs, it.dac);
         end else if (dac_ofs !== it.dac || (it.chk_dout && dout !== it.dv)) begin
            bad++;
            $display("FAIL %s: actual dac=%0d dout=%0d expected dac=%0d dout=%0d",
                     it.tag, $signed(dac_ofs), dout, $signed(it.dac), it.dv);
         end
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic expect_at(int d, logic [7:0] dac, logic [9:0] dv, bit chk, string tag);
      item_t it;
      it.due = cyc + d; it.dac = dac; it.dv = dv; it.chk_dout = chk; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr(logic [2:0] a, logic [9:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic feed(logic [9:0] s, logic pe);
      sample = s; pix_en = pe; clamp = 1'b1;
      step();
   endtask

   task automatic group8(logic [9:0] s);
      for (int i = 0; i < 8; i++) feed(s, 1'b1);
   endtask

   task automatic close_and_expect(logic [7:0] dac, string tag);
      clamp = 1'b0; pix_en = 1'b0;
      expect_at(2, dac, '0, 0, tag);
      repeat (3) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) step();
      rst = 1'b0;
      expect_at(0, 8'd0, 10'd0, 1, "R1 reset");
      step();

      // R2 presets, R8 manual selection
      wr(3'd2, 10'd20);
      expect_at(1, 8'd20, '0, 0, "R2 preset0 write");
      wr(3'd3, 10'h0FB);
      wr(3'd4, 10'd100);
      wr(3'd5, 10'h080);
      step();
      line_sel = 2'd1; sample = 10'h155; step();
      expect_at(0, 8'hFB, 10'h155, 1, "R8 line1");
      line_sel = 2'd2; sample = 10'd3; step();
      expect_at(0, 8'd100, 10'd3, 1, "R8 line2");
      line_sel = 2'd3; step();
      expect_at(0, 8'h80, 10'd3, 1, "R8 line3");

      // R9 auxiliary forces preset 0
      aux_sel = 1'b1; step();
      expect_at(0, 8'd20, '0, 0, "R9 aux");
      aux_sel = 1'b0; line_sel = 2'd0; step();

      // R4 automatic loop
      wr(3'd1, 10'd64);
      wr(3'd0, 10'b0001);
      expect_at(1, 8'd0, '0, 0, "R2 auto enable");
      step();
      group8(10'd40);
      close_and_expect(8'd24, "R4 avg 40");
      feed(10'd10, 1); feed(10'd20, 1); feed(10'd30, 1); feed(10'd40, 1);
      feed(10'd50, 1); feed(10'd60, 1); feed(10'd70, 1); feed(10'd81, 1);
      close_and_expect(8'd43, "R4 floor avg");

      // R5 scale codes
      wr(3'd0, 10'b0011); step();
      group8(10'd100);
      close_and_expect(8'd25, "R5 code1");
      wr(3'd0, 10'b0101); step();
      group8(10'd67);
      close_and_expect(8'd24, "R5 code2 negative");
      wr(3'd0, 10'b0111); step();
      group8(10'd0);
      close_and_expect(8'd28, "R5 code3");

      // R3 pixel enable gaps
      wr(3'd0, 10'b0001); step();
      for (int i = 0; i < 8; i++) begin
         feed(10'd1000, 1'b0);
         feed(10'd72, 1'b1);
      end
      close_and_expect(8'd20, "R3 pix_en gaps");

      // R7 partial group discarded
      for (int i = 0; i < 5; i++) feed(10'd0, 1'b1);
      clamp = 1'b0; pix_en = 1'b0; step();
      for (int i = 0; i < 3; i++) feed(10'd0, 1'b1);
      clamp = 1'b0; pix_en = 1'b0;
      expect_at(3, 8'd20, '0, 0, "R7 discard");
      repeat (4) step();

      // R3 loop disabled ignores black samples
      line_sel = 2'd2;
      wr(3'd0, 10'b0000);
      expect_at(1, 8'd100, '0, 0, "R3 manual while off");
      step();
      group8(10'd0);
      clamp = 1'b0; pix_en = 1'b0; repeat (3) step();
      wr(3'd0, 10'b0001);
      expect_at(1, 8'd20, '0, 0, "R3 disabled no update");
      step();
      line_sel = 2'd0;

      // R6 saturation
      wr(3'd1, 10'd1023); step();
      group8(10'd0);
      close_and_expect(8'd127, "R6 high limit");
      group8(10'd0);
      close_and_expect(8'd127, "R6 stays high");
      wr(3'd1, 10'd0); step();
      group8(10'd1023);
      close_and_expect(8'h80, "R6 low limit");

      // R10 routing to data bus
      sample = 10'h2AA;
      wr(3'd0, 10'b1001);
      expect_at(1, 8'd0, 10'h380, 1, "R10 routed");
      step();
      wr(3'd0, 10'b0001);
      expect_at(1, 8'h80, 10'h2AA, 1, "R10 unrouted");
      repeat (3) step();

      if (q.size() != 0) begin
         bad++; total++;
         $display("FAIL drain: actual=%0d pending expected=0", q.size());
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule